// File: doc/BRIEF.md
# Video Memory Write-Slot Dispatcher

This block buffers pending video-memory writes in a small ring and releases them into three memories: a byte-wide video RAM (VRAM), a colour table RAM (CRAM) and a vertical-scroll RAM (VSRAM). Each request names a target, an address, a 16-bit value and a write kind. When accepted, the request is stamped with a due cycle taken from an internal free-running cycle counter. The delay is a fixed latency count times 16 clocks in wide display mode, or times 20 clocks otherwise.

A strobe marks each external access slot. On a strobe, the oldest buffered request is removed and written if its due cycle has been reached. A request that is not yet due stays at the head, and nothing happens on that slot. VRAM receives single bytes. A whole-word request writes the upper byte at the address as given. A partial request writes to the address with bit 0 inverted, and its kind decides which byte of the value is used.

Requests enter over a valid/ready port. A request is taken on a clock edge where `push_valid` and `push_ready` are both high. `push_ready` is low while the ring is full, and a held request must keep its fields stable until it is taken. The memory write ports are plain strobes with no back-pressure.

Top module: `vid_write_dispatch`

## Requirements
- R1: The ring holds DEPTH (4) requests. `push_ready` is high exactly when the ring is not full, and `fifo_full` and `fifo_empty` are never high together. A request offered while full is dropped and never written.
- R2: Requests are written in the order they were accepted. A strobe while the ring is empty writes nothing.
- R3: A request accepted on edge E with `wide_mode`=1 may be written by a strobe sampled no earlier than edge E+48; with `wide_mode`=0 the earliest is E+60. The mode is sampled only at acceptance.
- R4: Each strobe edge removes at most one request. The matching write enable is high for exactly the one cycle after that edge, with at most one of the three enables high. Without a strobe, nothing is written.
- R5: Target code 0 with kind 0 (whole word) writes the value's upper byte to VRAM at the unmodified address.
- R6: Target code 0 with a nonzero kind writes to VRAM at the address with bit 0 inverted. The data is the value's lower byte for kind 1, and the upper byte for kinds 2 (fill) and 3.
- R7: Target code 1 writes the full value to CRAM at word index address bits [6:1], masked to the CRAM size (64).
- R8: Target code 2 writes the full value to VSRAM at word index address bits [6:1] when that index is below 40. Otherwise the request is consumed and discarded.
- R9: Target code 3 consumes the request and writes nothing.
- R10: After reset the ring is empty, `push_ready` is high, all write enables are low, and `cycle_cnt` is 0. The counter then advances by one each clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | Wide display mode; selects the 16-clock latency unit |
| push_valid | input | 1 | Request offered |
| push_ready | output | 1 | Request can be accepted (ring not full) |
| push_target | input | 2 | 0 VRAM, 1 CRAM, 2 VSRAM, 3 none |
| push_kind | input | 2 | 0 whole word, 1 low byte partial, 2/3 fill partial |
| push_addr | input | 16 | Request address |
| push_data | input | 16 | Request value |
| slot_strobe | input | 1 | External access slot |
| cycle_cnt | output | CYC_W | Free-running cycle counter |
| fifo_empty | output | 1 | Ring holds no requests |
| fifo_full | output | 1 | Ring holds DEPTH requests |
| vram_we | output | 1 | VRAM byte write enable |
| vram_addr | output | 16 | VRAM byte address |
| vram_wdata | output | 8 | VRAM byte data |
| cram_we | output | 1 | CRAM write enable |
| cram_addr | output | CRAM_AW | CRAM word index |
| cram_wdata | output | 16 | CRAM word data |
| vsram_we | output | 1 | VSRAM write enable |
| vsram_addr | output | VSRAM_AW | VSRAM word index |
| vsram_wdata | output | 16 | VSRAM word data |

## Verification
The bench uses the default build: a four-deep ring, a latency count of 3, a 64-word CRAM and a 40-word VSRAM. With four entries, the full condition and pointer wrap are reached after a handful of pushes. The 48- and 60-cycle windows are short enough to strobe every cycle up to the due edge for each request. The 6-bit scroll index space is swept completely, which covers both the accepted indices and the discarded indices from 40 to 63, and all four VRAM kinds are tried in both modes.

// File: rtl/vwd_pkg.sv
`timescale 1ns/1ps
package vwd_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    TGT_VRAM  = 2'd0,
    TGT_CRAM  = 2'd1,
    TGT_VSRAM = 2'd2,
    TGT_NONE  = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    KIND_WORD  = 2'd0,
    KIND_LOW   = 2'd1,
    KIND_FILL  = 2'd2,
    KIND_FILL3 = 2'd3
  } kind_e;

  typedef struct packed {
    tgt_e              tgt;
    kind_e             kind;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/vwd_ring.sv
`timescale 1ns/1ps
// Circular request store. DEPTH must be a power of two so pointers wrap
// by plain truncation. The read pointer carries an extra top bit that
// marks the empty state.
module vwd_ring #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_en,
  input  logic [W-1:0] push_data,
  input  logic         pop_en,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  slots [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_nxt;
  logic [AW:0]   rd_q, rd_n;

  assign empty = rd_q[AW];
  assign full  = !rd_q[AW] && (rd_q[AW-1:0] == wr_q);
  assign head  = slots[rd_q[AW-1:0]];

  always_comb begin
    wr_n   = push_en ? wr_q + 1'b1 : wr_q;
    rd_nxt = rd_q[AW-1:0] + 1'b1;
    rd_n   = rd_q;
    if (rd_q[AW]) begin
      if (push_en) rd_n = {1'b0, wr_q};
    end else if (pop_en) begin
      rd_n = {(rd_nxt == wr_n), rd_nxt};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= {1'b1, {AW{1'b0}}};
    end else begin
      wr_q <= wr_n;
      rd_q <= rd_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_en) slots[wr_q] <= push_data;
  end
endmodule

// File: rtl/vwd_split.sv
`timescale 1ns/1ps
// Turns one request into the write strobe, address and data of its target.
module vwd_split
  import vwd_pkg::*;
#(
  parameter int VSRAM_WORDS = 40,
  parameter int CRAM_AW     = 6,
  parameter int VSRAM_AW    = 6
) (
  input  logic                go,
  input  wr_req_t             req,
  output logic                vram_we,
  output logic [ADDR_W-1:0]   vram_addr,
  output logic [7:0]          vram_data,
  output logic                cram_we,
  output logic [CRAM_AW-1:0]  cram_addr,
  output logic [DATA_W-1:0]   cram_data,
  output logic                vsram_we,
  output logic [VSRAM_AW-1:0] vsram_addr,
  output logic [DATA_W-1:0]   vsram_data
);
  logic [5:0] word;
  assign word = req.addr[6:1];

  always_comb begin
    vram_we    = 1'b0;
    vram_addr  = '0;
    vram_data  = '0;
    cram_we    = 1'b0;
    cram_addr  = '0;
    cram_data  = '0;
    vsram_we   = 1'b0;
    vsram_addr = '0;
    vsram_data = '0;
    unique case (req.tgt)
      TGT_VRAM: begin
        vram_we   = go;
        vram_addr = (req.kind == KIND_WORD) ? req.addr
                                            : {req.addr[ADDR_W-1:1], ~req.addr[0]};
        vram_data = (req.kind == KIND_LOW) ? req.data[7:0] : req.data[15:8];
      end
      TGT_CRAM: begin
        cram_we   = go;
        cram_addr = word[CRAM_AW-1:0];
        cram_data = req.data;
      end
      TGT_VSRAM: begin
        vsram_we   = go && (int'(word) < VSRAM_WORDS);
        vsram_addr = word[VSRAM_AW-1:0];
        vsram_data = req.data;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vid_write_dispatch.sv
`timescale 1ns/1ps
module vid_write_dispatch
  import vwd_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int LATENCY     = 3,
  parameter int CYC_W       = 16,
  parameter int CRAM_WORDS  = 64,
  parameter int VSRAM_WORDS = 40,
  parameter int CRAM_AW     = $clog2(CRAM_WORDS),
  parameter int VSRAM_AW    = $clog2(VSRAM_WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wide_mode,
  input  logic                push_valid,
  output logic                push_ready,
  input  logic [1:0]          push_target,
  input  logic [1:0]          push_kind,
  input  logic [15:0]         push_addr,
  input  logic [15:0]         push_data,
  input  logic                slot_strobe,
  output logic [CYC_W-1:0]    cycle_cnt,
  output logic                fifo_empty,
  output logic                fifo_full,
  output logic                vram_we,
  output logic [15:0]         vram_addr,
  output logic [7:0]          vram_wdata,
  output logic                cram_we,
  output logic [CRAM_AW-1:0]  cram_addr,
  output logic [15:0]         cram_wdata,
  output logic                vsram_we,
  output logic [VSRAM_AW-1:0] vsram_addr,
  output logic [15:0]         vsram_wdata
);
  localparam logic [CYC_W-1:0] DLY_WIDE   = CYC_W'(LATENCY * 16);
  localparam logic [CYC_W-1:0] DLY_NARROW = CYC_W'(LATENCY * 20);
  localparam int ENT_W = $bits(wr_req_t) + CYC_W;

  logic [CYC_W-1:0] cyc_q, head_due;
  wr_req_t          in_req, head_req;
  logic [ENT_W-1:0] in_ent, head_ent;
  logic             push_fire, head_ready, pop;

  // split outputs before the port registers
  logic                s_vram_we, s_cram_we, s_vsram_we;
  logic [15:0]         s_vram_addr;
  logic [7:0]          s_vram_data;
  logic [CRAM_AW-1:0]  s_cram_addr;
  logic [15:0]         s_cram_data, s_vsram_data;
  logic [VSRAM_AW-1:0] s_vsram_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_q + 1'b1;
  end
  assign cycle_cnt = cyc_q;

  assign push_ready = !fifo_full;
  assign push_fire  = push_valid && push_ready;

  always_comb begin
    in_req.tgt  = tgt_e'(push_target);
    in_req.kind = kind_e'(push_kind);
    in_req.addr = push_addr;
    in_req.data = push_data;
  end
  assign in_ent = {in_req, cyc_q + (wide_mode ? DLY_WIDE : DLY_NARROW)};

  vwd_ring #(.DEPTH(DEPTH), .W(ENT_W)) ring_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_fire),
    .push_data (in_ent),
    .pop_en    (pop),
    .head      (head_ent),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  assign {head_req, head_due} = head_ent;
  // wrap-safe due test: valid while an entry waits under half the counter range
  assign head_ready = !fifo_empty && ($signed(cyc_q - head_due) >= 0);
  assign pop        = slot_strobe && head_ready;

  vwd_split #(
    .VSRAM_WORDS (VSRAM_WORDS),
    .CRAM_AW     (CRAM_AW),
    .VSRAM_AW    (VSRAM_AW)
  ) split_i (
    .go         (pop),
    .req        (head_req),
    .vram_we    (s_vram_we),
    .vram_addr  (s_vram_addr),
    .vram_data  (s_vram_data),
    .cram_we    (s_cram_we),
    .cram_addr  (s_cram_addr),
    .cram_data  (s_cram_data),
    .vsram_we   (s_vsram_we),
    .vsram_addr (s_vsram_addr),
    .vsram_data (s_vsram_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vram_we     <= 1'b0;
      vram_addr   <= '0;
      vram_wdata  <= '0;
      cram_we     <= 1'b0;
      cram_addr   <= '0;
      cram_wdata  <= '0;
      vsram_we    <= 1'b0;
      vsram_addr  <= '0;
      vsram_wdata <= '0;
    end else begin
      vram_we     <= s_vram_we;
      vram_addr   <= s_vram_addr;
      vram_wdata  <= s_vram_data;
      cram_we     <= s_cram_we;
      cram_addr   <= s_cram_addr;
      cram_wdata  <= s_cram_data;
      vsram_we    <= s_vsram_we;
      vsram_addr  <= s_vsram_addr;
      vsram_wdata <= s_vsram_data;
    end
  end
endmodule

// File: rtl/vwd_checker.sv
`timescale 1ns/1ps
module vwd_checker #(
  parameter int VSRAM_WORDS = 40,
  parameter int VSRAM_AW    = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                slot_strobe,
  input logic                push_ready,
  input logic                fifo_full,
  input logic                fifo_empty,
  input logic                vram_we,
  input logic                cram_we,
  input logic                vsram_we,
  input logic [VSRAM_AW-1:0] vsram_addr
);
  logic any_we;
  assign any_we = vram_we || cram_we || vsram_we;

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vram_we, cram_we, vsram_we})); // R4
  AST_WRITE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    any_we |-> $past(slot_strobe)); // R4
  AST_FULL_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !push_ready); // R1
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty)); // R1
  AST_EMPTY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_strobe && fifo_empty) |=> !any_we); // R2
  AST_VSRAM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vsram_we |-> (int'(vsram_addr) < VSRAM_WORDS)); // R8
endmodule

bind vid_write_dispatch vwd_checker #(
  .VSRAM_WORDS (VSRAM_WORDS),
  .VSRAM_AW    (VSRAM_AW)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .slot_strobe (slot_strobe),
  .push_ready  (push_ready),
  .fifo_full   (fifo_full),
  .fifo_empty  (fifo_empty),
  .vram_we     (vram_we),
  .cram_we     (cram_we),
  .vsram_we    (vsram_we),
  .vsram_addr  (vsram_addr)
);

// File: tb/vid_write_dispatch_tb_top.sv
`timescale 1ns/1ps
module vid_write_dispatch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic        push_valid = 1'b0;
  logic        push_ready;
  logic [1:0]  push_target = '0;
  logic [1:0]  push_kind = '0;
  logic [15:0] push_addr = '0;
  logic [15:0] push_data = '0;
  logic        slot_strobe = 1'b0;
  logic [15:0] cycle_cnt;
  logic        fifo_empty, fifo_full;
  logic        vram_we, cram_we, vsram_we;
  logic [15:0] vram_addr;
  logic [7:0]  vram_wdata;
  logic [5:0]  cram_addr, vsram_addr;
  logic [15:0] cram_wdata, vsram_wdata;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  vid_write_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .push_valid(push_valid), .push_ready(push_ready),
    .push_target(push_target), .push_kind(push_kind),
    .push_addr(push_addr), .push_data(push_data),
    .slot_strobe(slot_strobe), .cycle_cnt(cycle_cnt),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .vram_we(vram_we), .vram_addr(vram_addr), .vram_wdata(vram_wdata),
    .cram_we(cram_we), .cram_addr(cram_addr), .cram_wdata(cram_wdata),
    .vsram_we(vsram_we), .vsram_addr(vsram_addr), .vsram_wdata(vsram_wdata)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push_one(input logic [1:0] t, input logic [1:0] k,
                          input logic [15:0] a, input logic [15:0] d, input logic w);
    push_target = t; push_kind = k; push_addr = a; push_data = d;
    wide_mode = w; push_valid = 1'b1;
    tick();
    push_valid = 1'b0;
    wide_mode = ~w;  // later mode changes must not matter (R3)
  endtask

  task automatic run_one(input logic [1:0] t, input logic [1:0] k,
                         input logic [15:0] a, input logic [15:0] d,
                         input logic w, input string req);
    int dly = w ? 48 : 60;
    logic [2:0]  ew = 3'b000;
    logic [15:0] ea;
    logic [7:0]  ed;
    int idx = (int'(a) >> 1) & 63;
    push_one(t, k, a, d, w);
    for (int n = 1; n < dly; n++) begin
      slot_strobe = 1'b1;
      tick();
      slot_strobe = 1'b0;
      if (n == dly - 1)
        chk("R3 strobe before due", {29'd0, vram_we, cram_we, vsram_we}, 32'd0);
    end
    slot_strobe = 1'b1;
    tick();
    slot_strobe = 1'b0;
    ea = (k == 2'd0) ? a : (a ^ 16'h0001);
    ed = (k == 2'd1) ? d[7:0] : d[15:8];
    case (t)
      2'd0: ew = 3'b100;
      2'd1: ew = 3'b010;
      2'd2: ew = (idx < 40) ? 3'b001 : 3'b000;
      default: ew = 3'b000;
    endcase
    chk({req, " enables at due strobe"}, {29'd0, vram_we, cram_we, vsram_we}, {29'd0, ew});
    if (ew[2]) chk({req, " vram addr/data"}, {8'd0, vram_addr, vram_wdata}, {8'd0, ea, ed});
    if (ew[1]) chk({req, " cram index/data"}, {10'd0, cram_addr, cram_wdata}, {10'd0, 6'(idx), d});
    if (ew[0]) chk({req, " vsram index/data"}, {10'd0, vsram_addr, vsram_wdata}, {10'd0, 6'(idx), d});
    tick();
    chk("R4 enable lasts one cycle", {29'd0, vram_we, cram_we, vsram_we}, 32'd0);
    chk({req, " request consumed"}, {31'd0, fifo_empty}, 32'd1);
  endtask

  initial begin
    #750000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] va [5];
    va[0] = 16'h0000; va[1] = 16'h0001; va[2] = 16'h1234;
    va[3] = 16'hFFFF; va[4] = 16'hABCD;

    repeat (3) tick();
    rst_n = 1'b1;
    // R10 reset state
    chk("R10 empty after reset", {31'd0, fifo_empty}, 32'd1);
    chk("R10 not full after reset", {31'd0, fifo_full}, 32'd0);
    chk("R10 push_ready after reset", {31'd0, push_ready}, 32'd1);
    chk("R10 enables low after reset", {29'd0, vram_we, cram_we, vsram_we}, 32'd0);
    chk("R10 counter zero", {16'd0, cycle_cnt}, 32'd0);
    repeat (5) tick();
    chk("R10 counter advances", {16'd0, cycle_cnt}, 32'd5);

    // R2 strobe on empty ring
    slot_strobe = 1'b1; tick(); slot_strobe = 1'b0; tick();
    chk("R2 empty strobe writes nothing", {29'd0, vram_we, cram_we, vsram_we}, 32'd0);

    // R1 fill the ring, R2 order, R4 one per strobe
    for (int i = 0; i < 4; i++)
      push_one(2'd0, 2'd0, 16'h0100 + 16'(i), 16'(i) << 8, 1'b1);
    chk("R1 full after four pushes", {31'd0, fifo_full}, 32'd1);
    chk("R1 push_ready low when full", {31'd0, push_ready}, 32'd0);
    push_target = 2'd0; push_kind = 2'd0; push_addr = 16'h0999;
    push_data = 16'hEE00; wide_mode = 1'b1; push_valid = 1'b1;
    tick();
    push_valid = 1'b0;
    chk("R1 still full after refused push", {31'd0, fifo_full}, 32'd1);
    repeat (50) tick();
    chk("R4 no write without strobe", {29'd0, vram_we, cram_we, vsram_we}, 32'd0);
    slot_strobe = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R4 one write per strobe", {29'd0, vram_we, cram_we, vsram_we}, 32'b100);
      chk("R2 drain order", {16'd0, vram_addr}, {16'd0, 16'h0100 + 16'(i)});
      chk("R2 drain data", {24'd0, vram_wdata}, 32'(i));
      if (i == 0) chk("R1 push_ready after pop", {31'd0, push_ready}, 32'd1);
    end
    tick();
    slot_strobe = 1'b0;
    chk("R1 refused request never written", {29'd0, vram_we, cram_we, vsram_we}, 32'd0);
    chk("R1 empty after drain", {31'd0, fifo_empty}, 32'd1);

    // VRAM kinds and both modes (R5, R6, R3)
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 5; j++)
        run_one(2'd0, 2'(k), va[j], 16'hA5C3 ^ va[j] ^ 16'(k * 4369), 1'(j % 2),
                (k == 0) ? "R5" : "R6");

    // CRAM index sweep (R7)
    for (int i = 0; i < 64; i++)
      run_one(2'd1, 2'd0, 16'(i * 2 + (i % 2) + i * 512), 16'(i * 1021), 1'(i % 2), "R7");

    // VSRAM index sweep incl. discard region (R8)
    for (int i = 0; i < 64; i++)
      run_one(2'd2, 2'd0, 16'(i * 2 + (i % 2)) | 16'hC000, 16'(i * 733 + 5), 1'(i % 2), "R8");

    // null target (R9)
    run_one(2'd3, 2'd0, 16'h1234, 16'h5678, 1'b0, "R9");
    run_one(2'd3, 2'd1, 16'h0042, 16'h9ABC, 1'b1, "R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule